// File: doc/BRIEF.md
# ADC End-Point Linearity Calculator

This block turns a set of measured input transition levels of an N-bit analog-to-digital converter into its static linearity profile. The levels enter one per handshake as unsigned 16-bit values, lowest transition first. After the whole set has arrived, a start pulse launches the calculation.

The block derives the reference step from the two outer transitions. This keeps offset and full-scale error out of the result. It then emits one record per output code in ascending order. Each record carries the code width, the differential nonlinearity (DNL) and the integral nonlinearity (INL), both in signed fixed point with 10 fractional bits and expressed in units of the reference step. When the last record has been taken, a done pulse marks the end of the run. At that point, the worst absolute DNL, the worst absolute INL, a missing-code flag, a non-monotonic flag and an invalid-span flag are valid. They stay valid until the next accepted start.

Both data streams use valid/ready. On the input side, a level is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while the store is full or a run is in progress, so the source simply holds its data. On the output side, a record is held unchanged for as long as `out_valid` is high and `out_ready` is low, and it moves on only after a handshake. Calculation stalls while the sink pushes back; no record is dropped or skipped.

Top module: `adc_lin_calc`

## Requirements
- R1: After reset, and again after each done pulse, `in_ready` is high until 2^N-1 levels have been accepted. The k-th accepted level is transition k. While the set is full, `in_valid` has no effect.
- R2: `start` takes effect only when the block holds a full set and no run is in progress. A start pulse before the set is complete, or during a run, changes neither the records nor the flags.
- R3: A run emits 2^N records with `out_code` counting 0, 1, …, 2^N-1. Each record stays stable while `out_valid` is high and `out_ready` is low.
- R4: For codes 1 to 2^N-2, the width is transition[k+1] − transition[k], given as a signed 17-bit value. For codes 0 and 2^N-1, the width is 0, `out_dnl_def` is 0 and `out_dnl` is 0.
- R5: Let span be the last transition minus the first. For an interior code of a monotonic set, DNL = floor(width·(2^N−2)·1024 / span) − 1024. It is saturated at +32767, and `out_dnl_def` is 1.
- R6: INL of code m is the saturating sum of the DNL of codes 1 to m−1. So code 1 has INL 0, and code 2^N−1 carries the sum of all DNL. Code 0 has `out_inl_def`=0 and `out_inl`=0.
- R7: After done, `max_dnl` and `max_inl` hold the largest absolute value among the defined DNL and INL values of the run. Both are 0 when no value was defined.
- R8: `missing` is set after done if any interior code had zero width. Such a code reports DNL −1024 when defined.
- R9: If any level is strictly below the level accepted before it, `nonmono` is set. Every record of that run then has both definition bits at 0 and DNL and INL at 0, while widths are still reported and may be negative.
- R10: If the last transition is not above the first, `span_err` is set, no record is emitted and done pulses.
- R11: `done` pulses for one cycle right after the final record is accepted, or right after start in the R10 case. On the next cycle `in_ready` is high for a new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transition level offered |
| in_ready | output | 1 | Store accepts a level |
| in_level | input | 16 | Transition level, unsigned |
| start | input | 1 | Launch a calculation on the stored set |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Sink takes the record |
| out_code | output | N | Code of the record |
| out_width | output | 17 | Code width, signed, in level units |
| out_dnl | output | 16 | DNL, signed, 10 fractional bits |
| out_dnl_def | output | 1 | DNL is defined |
| out_inl | output | 16 | INL, signed, 10 fractional bits |
| out_inl_def | output | 1 | INL is defined |
| done | output | 1 | One-cycle end-of-run pulse |
| max_dnl | output | 16 | Worst absolute DNL, 10 fractional bits |
| max_inl | output | 16 | Worst absolute INL, 10 fractional bits |
| missing | output | 1 | A zero-width code was seen |
| nonmono | output | 1 | A descending level pair was seen |
| span_err | output | 1 | Last transition not above the first |

## Verification
The output handshake of a record also advances the INL accumulator, updates the worst-case trackers and may set the missing flag, all on the same clock edge. The bench applies back-pressure so that records wait several cycles before the edge that takes them. It also places zero-width and descending pairs next to defined codes, and a scoreboard compares every accepted record and the final flags with values computed from the rules above. A start pulse is driven in the middle of a stalled stream, so that it falls in the same cycle as a pending record; the scoreboard confirms the run goes on unchanged.

// File: rtl/adc_lin_pkg.sv
package adc_lin_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_PREP,
    ST_DIV,
    ST_OUT,
    ST_DONE
  } lin_state_t;
endpackage

// File: rtl/adc_lin_store.sv
module adc_lin_store #(
  parameter int NBITS = 3,
  parameter int LVL_W = 16
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_idx,
  input  logic [LVL_W-1:0] wr_data,
  input  logic [NBITS-1:0] rd_idx_a,
  input  logic [NBITS-1:0] rd_idx_b,
  output logic [LVL_W-1:0] rd_a,
  output logic [LVL_W-1:0] rd_b
);
  localparam int DEPTH = (1 << NBITS) - 1;

  logic [LVL_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == NBITS'(g))) mem[g] <= wr_data;
    end
  end

  always_comb begin
    rd_a = (rd_idx_a < NBITS'(DEPTH)) ? mem[rd_idx_a] : '0;
    rd_b = (rd_idx_b < NBITS'(DEPTH)) ? mem[rd_idx_b] : '0;
  end
endmodule

// File: rtl/adc_lin_div.sv
module adc_lin_div #(
  parameter int NUM_W = 29,
  parameter int DEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             fin,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [NUM_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [DEN_W:0]   rem_sh;
  logic [DEN_W:0]   rem_nx;
  logic             take;

  always_comb begin
    rem_sh = {rem[DEN_W-1:0], shreg[NUM_W-1]};
    take   = rem_sh >= {1'b0, den};
    rem_nx = take ? (rem_sh - {1'b0, den}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem   <= '0;
      shreg <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      fin   <= 1'b0;
    end else if (go) begin
      rem   <= '0;
      shreg <= num;
      cnt   <= CNT_W'(NUM_W);
      busy  <= 1'b1;
      fin   <= 1'b0;
    end else if (busy) begin
      rem   <= rem_nx;
      shreg <= {shreg[NUM_W-2:0], take};
      cnt   <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        busy <= 1'b0;
        fin  <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quo = shreg;
endmodule

// File: rtl/adc_lin_acc.sv
module adc_lin_acc #(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    upd,
  input  logic signed [OUT_W-1:0] dnl,
  input  logic                    dnl_def,
  input  logic                    inl_def,
  output logic signed [OUT_W-1:0] inl,
  output logic [OUT_W-1:0]        max_dnl,
  output logic [OUT_W-1:0]        max_inl
);
  localparam logic signed [OUT_W-1:0] POS_LIM = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] NEG_LIM = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [OUT_W-1:0] acc;
  logic signed [OUT_W:0]   sum;
  logic signed [OUT_W-1:0] sum_sat;
  logic [OUT_W-1:0]        dnl_mag;
  logic [OUT_W-1:0]        inl_mag;

  always_comb begin
    sum = {acc[OUT_W-1], acc} + {dnl[OUT_W-1], dnl};
    if (sum[OUT_W] != sum[OUT_W-1]) sum_sat = sum[OUT_W] ? NEG_LIM : POS_LIM;
    else                            sum_sat = sum[OUT_W-1:0];
    dnl_mag = dnl[OUT_W-1] ? (~dnl + 1'b1) : dnl;
    inl_mag = acc[OUT_W-1] ? (~acc + 1'b1) : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      max_dnl <= '0;
      max_inl <= '0;
    end else if (clr) begin
      acc     <= '0;
      max_dnl <= '0;
      max_inl <= '0;
    end else if (upd) begin
      if (inl_def && (inl_mag > max_inl)) max_inl <= inl_mag;
      if (dnl_def) begin
        if (dnl_mag > max_dnl) max_dnl <= dnl_mag;
        acc <= sum_sat;
      end
    end
  end

  assign inl = acc;
endmodule

// File: rtl/adc_lin_calc.sv
module adc_lin_calc #(
  parameter int NBITS = 3,
  parameter int LVL_W = 16,
  parameter int FRAC  = 10,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LVL_W-1:0]        in_level,
  input  logic                    start,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [NBITS-1:0]        out_code,
  output logic signed [LVL_W:0]   out_width,
  output logic signed [OUT_W-1:0] out_dnl,
  output logic                    out_dnl_def,
  output logic signed [OUT_W-1:0] out_inl,
  output logic                    out_inl_def,
  output logic                    done,
  output logic [OUT_W-1:0]        max_dnl,
  output logic [OUT_W-1:0]        max_inl,
  output logic                    missing,
  output logic                    nonmono,
  output logic                    span_err
);
  import adc_lin_pkg::*;

  localparam int NT    = (1 << NBITS) - 1;
  localparam int DIVS  = (1 << NBITS) - 2;
  localparam int NUM_W = LVL_W + NBITS + FRAC;
  localparam int ONE   = 1 << FRAC;
  localparam logic [NBITS-1:0]    LAST_C = NBITS'(NT);
  localparam logic signed [NUM_W:0] MAXPOS = (NUM_W+1)'((1 << (OUT_W-1)) - 1);

  lin_state_t state;

  logic [NBITS-1:0]        load_cnt;
  logic [LVL_W-1:0]        prev_lvl;
  logic                    bad_pend;
  logic [NBITS-1:0]        code;
  logic [LVL_W-1:0]        span;
  logic signed [LVL_W:0]   rec_width;
  logic signed [OUT_W-1:0] rec_dnl;
  logic                    rec_dnl_def;

  logic [NBITS-1:0]        rd_idx_a, rd_idx_b;
  logic [LVL_W-1:0]        rd_a, rd_b;
  logic                    wr_en;
  logic                    launch;
  logic                    interior;
  logic signed [LVL_W:0]   width_c;
  logic [LVL_W-1:0]        width_u;
  logic [NUM_W-1:0]        num_c;
  logic                    div_go, div_fin;
  logic [NUM_W-1:0]        quo;
  logic signed [NUM_W:0]   dq;
  logic signed [OUT_W-1:0] dnl_c;
  logic                    rec_take;

  assign in_ready  = (state == ST_LOAD) && (load_cnt != LAST_C);
  assign wr_en     = in_valid && in_ready;
  assign launch    = (state == ST_LOAD) && start && (load_cnt == LAST_C);
  assign interior  = (code != '0) && (code != LAST_C);
  assign out_valid = (state == ST_OUT);
  assign rec_take  = out_valid && out_ready;
  assign done      = (state == ST_DONE);
  assign div_go    = (state == ST_PREP) && interior && !nonmono;

  always_comb begin
    if (state == ST_LOAD) begin
      rd_idx_a = NBITS'(NT - 1);
      rd_idx_b = '0;
    end else begin
      rd_idx_a = code;
      rd_idx_b = code - NBITS'(1);
    end
    width_c = $signed({1'b0, rd_a}) - $signed({1'b0, rd_b});
    width_u = rd_a - rd_b;
    num_c   = (NUM_W'(width_u) * NUM_W'(DIVS)) << FRAC;
    dq      = $signed({1'b0, quo}) - $signed((NUM_W+1)'(ONE));
    dnl_c   = (dq > MAXPOS) ? OUT_W'(MAXPOS) : OUT_W'(dq);
  end

  adc_lin_store #(.NBITS(NBITS), .LVL_W(LVL_W)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (load_cnt),
    .wr_data  (in_level),
    .rd_idx_a (rd_idx_a),
    .rd_idx_b (rd_idx_b),
    .rd_a     (rd_a),
    .rd_b     (rd_b)
  );

  adc_lin_div #(.NUM_W(NUM_W), .DEN_W(LVL_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (num_c),
    .den   (span),
    .fin   (div_fin),
    .quo   (quo)
  );

  adc_lin_acc #(.OUT_W(OUT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .upd     (rec_take),
    .dnl     (rec_dnl),
    .dnl_def (rec_dnl_def),
    .inl_def (out_inl_def),
    .inl     (out_inl),
    .max_dnl (max_dnl),
    .max_inl (max_inl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_LOAD;
      load_cnt    <= '0;
      prev_lvl    <= '0;
      bad_pend    <= 1'b0;
      code        <= '0;
      span        <= '0;
      rec_width   <= '0;
      rec_dnl     <= '0;
      rec_dnl_def <= 1'b0;
      missing     <= 1'b0;
      nonmono     <= 1'b0;
      span_err    <= 1'b0;
    end else begin
      unique case (state)
        ST_LOAD: begin
          if (wr_en) begin
            load_cnt <= load_cnt + NBITS'(1);
            prev_lvl <= in_level;
            if ((load_cnt != '0) && (in_level < prev_lvl)) bad_pend <= 1'b1;
          end else if (launch) begin
            span     <= rd_a - rd_b;
            span_err <= !(rd_a > rd_b);
            nonmono  <= bad_pend;
            missing  <= 1'b0;
            code     <= '0;
            state    <= (rd_a > rd_b) ? ST_PREP : ST_DONE;
          end
        end
        ST_PREP: begin
          if (!interior) begin
            rec_width   <= '0;
            rec_dnl     <= '0;
            rec_dnl_def <= 1'b0;
            state       <= ST_OUT;
          end else begin
            rec_width <= width_c;
            if (nonmono) begin
              rec_dnl     <= '0;
              rec_dnl_def <= 1'b0;
              state       <= ST_OUT;
            end else begin
              state <= ST_DIV;
            end
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            rec_dnl     <= dnl_c;
            rec_dnl_def <= 1'b1;
            state       <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            if (interior && (rec_width == '0)) missing <= 1'b1;
            if (code == LAST_C) begin
              state <= ST_DONE;
            end else begin
              code  <= code + NBITS'(1);
              state <= ST_PREP;
            end
          end
        end
        ST_DONE: begin
          state    <= ST_LOAD;
          load_cnt <= '0;
          bad_pend <= 1'b0;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  assign out_code    = code;
  assign out_width   = rec_width;
  assign out_dnl     = rec_dnl;
  assign out_dnl_def = rec_dnl_def;
  assign out_inl_def = (code != '0) && !nonmono;
endmodule

// File: rtl/adc_lin_calc_chk.sv
module adc_lin_calc_chk #(
  parameter int NBITS = 3,
  parameter int LVL_W = 16,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [NBITS-1:0]        out_code,
  input logic signed [LVL_W:0]   out_width,
  input logic signed [OUT_W-1:0] out_dnl,
  input logic                    out_dnl_def,
  input logic signed [OUT_W-1:0] out_inl,
  input logic                    out_inl_def,
  input logic                    done,
  input logic                    missing,
  input logic                    nonmono,
  input logic                    span_err
);
  localparam logic [NBITS-1:0] LAST_C = NBITS'((1 << NBITS) - 1);

  // R1: input side is closed while records are presented
  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  // R3: a stalled record holds still
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_width)
                                   && $stable(out_dnl) && $stable(out_inl)));

  // R4: outer codes have no width and no DNL
  assert_outer_undef_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ((out_code == '0) || (out_code == LAST_C))) |-> (!out_dnl_def && (out_width == '0)));

  // R5: undefined DNL reads as zero
  assert_undef_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_dnl_def) |-> (out_dnl == '0));

  // R6: INL of code 1 is zero, code 0 has none
  assert_inl_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_code == NBITS'(1)) && out_inl_def) |-> (out_inl == '0));
  assert_inl_code0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_code == '0)) |-> (!out_inl_def && (out_inl == '0)));

  // R8: a taken zero-width defined code raises the flag
  assert_missing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_dnl_def && (out_width == '0)) |=> missing);

  // R9: descending set suppresses all DNL and INL
  assert_nonmono_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nonmono) |-> (!out_dnl_def && !out_inl_def));

  // R10: invalid span gives no records
  assert_span_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    span_err |-> !out_valid);

  // R11: last record taken leads to done, then to an open input
  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && (out_code == LAST_C)) |=> done);
  assert_reopen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> in_ready);
endmodule

bind adc_lin_calc adc_lin_calc_chk #(.NBITS(NBITS), .LVL_W(LVL_W), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_code    (out_code),
  .out_width   (out_width),
  .out_dnl     (out_dnl),
  .out_dnl_def (out_dnl_def),
  .out_inl     (out_inl),
  .out_inl_def (out_inl_def),
  .done        (done),
  .missing     (missing),
  .nonmono     (nonmono),
  .span_err    (span_err)
);

// File: tb/adc_lin_calc_bench.sv
module adc_lin_calc_bench;
  localparam int NB = 3;
  localparam int NT = (1 << NB) - 1;
  localparam int NC = 1 << NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_level = '0;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, done;
  logic [NB-1:0] out_code;
  logic signed [16:0] out_width;
  logic signed [15:0] out_dnl, out_inl;
  logic out_dnl_def, out_inl_def;
  logic [15:0] max_dnl, max_inl;
  logic missing, nonmono, span_err;

  always #5 clk = ~clk;

  adc_lin_calc u_adc_lin_calc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_level(in_level),
    .start(start), .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .out_width(out_width), .out_dnl(out_dnl), .out_dnl_def(out_dnl_def), .out_inl(out_inl),
    .out_inl_def(out_inl_def), .done(done), .max_dnl(max_dnl), .max_inl(max_inl),
    .missing(missing), .nonmono(nonmono), .span_err(span_err)
  );

  typedef struct {
    int code; int width; int dnl; bit dd; int inl; bit id;
  } rec_t;

  rec_t exp_q[$];
  int   lvl [NT];
  int   total = 0, bad = 0;
  int   done_cnt = 0, cyc = 0;
  bit   bp_mode = 0;
  int   e_maxd, e_maxi;
  bit   e_miss, e_nm, e_err;
  bit   held = 0;
  int   h_code, h_w, h_d, h_i;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic model();
    int span, acc;
    rec_t r;
    e_nm = 0; e_miss = 0; e_maxd = 0; e_maxi = 0; acc = 0;
    for (int i = 1; i < NT; i++) if (lvl[i] < lvl[i-1]) e_nm = 1;
    span  = lvl[NT-1] - lvl[0];
    e_err = (span <= 0);
    if (!e_err) begin
      for (int c = 0; c < NC; c++) begin
        bit inner;
        inner   = (c != 0) && (c != NC-1);
        r.code  = c;
        r.width = inner ? (lvl[c] - lvl[c-1]) : 0;
        if (inner && r.width == 0) e_miss = 1;
        r.dd  = inner && !e_nm;
        r.dnl = r.dd ? sat16((r.width * (NC-2) * 1024) / span - 1024) : 0;
        r.id  = (c != 0) && !e_nm;
        r.inl = r.id ? acc : 0;
        if (r.id && iabs(acc) > e_maxi) e_maxi = iabs(acc);
        if (r.dd) begin
          if (iabs(r.dnl) > e_maxd) e_maxd = iabs(r.dnl);
          acc = sat16(acc + r.dnl);
        end
        exp_q.push_back(r);
      end
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      out_ready = 1'b0;
      held = 0;
    end else begin
      cyc++;
      if (held)
        chk(out_valid && int'(out_code) == h_code && int'(out_width) == h_w &&
            int'(out_dnl) == h_d && int'(out_inl) == h_i, "R3 record held under back-pressure",
            int'(out_code), h_code);
      out_ready = bp_mode ? ((cyc % 3) == 2) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected record", int'(out_code), -1);
        end else begin
          rec_t e;
          e = exp_q.pop_front();
          chk(int'(out_code) == e.code, "R3 code order", int'(out_code), e.code);
          chk(int'(out_width) == e.width, "R4 width", int'(out_width), e.width);
          chk(out_dnl_def == e.dd, "R4 dnl defined bit", int'(out_dnl_def), int'(e.dd));
          chk(int'(out_dnl) == e.dnl, "R5 dnl value", int'(out_dnl), e.dnl);
          chk(out_inl_def == e.id, "R6 inl defined bit", int'(out_inl_def), int'(e.id));
          chk(int'(out_inl) == e.inl, "R6 inl value", int'(out_inl), e.inl);
        end
      end
      held = out_valid && !out_ready;
      if (held) begin
        h_code = int'(out_code); h_w = int'(out_width);
        h_d = int'(out_dnl); h_i = int'(out_inl);
      end
      if (done) begin
        chk(exp_q.size() == 0, "R11 done after final record", exp_q.size(), 0);
        done_cnt++;
      end
    end
  end

  task automatic load_range(input int from, input int upto);
    for (int i = from; i < upto; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_level = 16'(lvl[i]);
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int prev);
    int n = 0;
    while (done_cnt == prev && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done_cnt != prev, "R11 done pulse seen", done_cnt, prev + 1);
  endtask

  task automatic check_flags(input string tag);
    chk(int'(max_dnl) == e_maxd, {tag, " R7 max dnl"}, int'(max_dnl), e_maxd);
    chk(int'(max_inl) == e_maxi, {tag, " R7 max inl"}, int'(max_inl), e_maxi);
    chk(missing == e_miss, {tag, " R8 missing"}, int'(missing), int'(e_miss));
    chk(nonmono == e_nm, {tag, " R9 nonmono"}, int'(nonmono), int'(e_nm));
    chk(span_err == e_err, {tag, " R10 span error"}, int'(span_err), int'(e_err));
    @(negedge clk);
    chk(in_ready == 1'b1, {tag, " R11 input reopened"}, int'(in_ready), 1);
  endtask

  task automatic run_set(input string tag, input bit bp, input bit mid_start);
    int d0;
    bp_mode = bp;
    model();
    load_range(0, NT);
    chk(in_ready == 1'b0, {tag, " R1 ready low when full"}, int'(in_ready), 0);
    @(negedge clk);
    in_valid = 1'b1; in_level = 16'hBEEF;   // R1: ignored while full
    @(negedge clk);
    in_valid = 1'b0;
    d0 = done_cnt;
    pulse_start();
    if (mid_start) begin
      repeat (50) @(negedge clk);
      start = 1'b1;                         // R2: ignored during a run
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(d0);
    check_flags(tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R3 reset out_valid", int'(out_valid), 0);
    chk(done == 1'b0, "R11 reset done", int'(done), 0);
    chk({missing, nonmono, span_err} == 3'b000, "R8 reset flags", int'({missing, nonmono, span_err}), 0);

    lvl = '{50, 150, 250, 350, 450, 550, 650};
    run_set("ideal", 0, 0);

    lvl = '{30, 145, 210, 380, 440, 515, 690};
    run_set("skewed", 1, 1);

    lvl = '{100, 200, 300, 300, 500, 600, 700};
    run_set("missing", 1, 0);

    lvl = '{100, 200, 350, 300, 500, 600, 700};
    run_set("descending", 0, 0);

    lvl = '{400, 400, 400, 400, 400, 400, 400};
    run_set("flat", 0, 0);
    chk(done_cnt == 5, "R10 done count after flat set", done_cnt, 5);

    // R2: start before the set is complete has no effect
    lvl = '{10, 60, 140, 200, 260, 330, 400};
    bp_mode = 1;
    load_range(0, 3);
    pulse_start();
    repeat (10) @(negedge clk);
    chk(out_valid == 1'b0, "R2 early start no record", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R2 early start input open", int'(in_ready), 1);
    chk(done_cnt == 5, "R2 early start no done", done_cnt, 5);
    model();
    load_range(3, NT);
    begin
      int d0;
      d0 = done_cnt;
      pulse_start();
      wait_done(d0);
    end
    check_flags("partial");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 6);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule